// File: doc/BRIEF.md
# Multi-PHY Cell Transmit Slave Port

This block is the PHY-side end of a shared cell transmit bus. Several PHY devices hang on one 5-bit address bus, one active-low enable strobe, one start-of-cell strobe and one 16-bit data bus. The ATM-layer master polls each device by putting its address on the bus. Only the device whose configured address is on the bus answers on the shared cell-available line. The line is tri-statable and is modelled here as a data bit plus an output enable.

A device becomes the write target when the master shows its address while the enable strobe is high and then pulls the strobe low. From then on the device takes one cell as 27 consecutive 16-bit words. The first word is marked by start-of-cell. The words go into a four-cell FIFO, and a cell is released to the line side only once all of its words have arrived. The line side drains the FIFO word by word with a read enable.

Top module: `mphy_cell_tx_port`

## Requirements
- R1: When `bus_addr` equals `MY_ADDR` at a clock edge and the committed cells plus any partially written cell number fewer than 4, both `cell_avail_oe` and `cell_avail` are 1 after that edge.
- R2: When `bus_addr` equals `MY_ADDR` and the committed cells plus any partially written cell number 4, `cell_avail_oe` is 1 and `cell_avail` is 0 after that edge.
- R3: When `bus_addr` differs from `MY_ADDR` (for example the null address 5'h1F), `cell_avail_oe` is 0 after that edge.
- R4: The port is selected when `bus_addr` equals `MY_ADDR` at an edge with `bus_en_n`=1. The selection holds unchanged while `bus_en_n`=0, whatever the address does. Words sent while the port is not selected are ignored.
- R5: A word with `bus_soc`=1 starts a cell at word 0. A word with `bus_soc`=0 when no cell is open is ignored.
- R6: A cell is committed on the edge that takes its 27th word. `line_valid` is 1 exactly when at least one committed cell is stored.
- R7: A `bus_soc`=1 word that arrives before the open cell has 27 words throws the partial cell away and restarts at word 0.
- R8: The FIFO holds 4 cells. A `bus_soc`=1 word that arrives while 4 cells are stored is dropped, no cell is opened, and `drop_flag` is 1 for the one cycle after that edge.
- R9: `line_data` shows the stored words in arrival order. `line_sop` is 1 on word 0 of a cell. `line_rd_en` advances only while `line_valid`=1.
- R10: After reset, `cell_avail_oe`, `cell_avail`, `line_valid` and `drop_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and line clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Shared poll/select address |
| bus_en_n | input | 1 | Active-low write enable strobe |
| bus_soc | input | 1 | Start-of-cell marker for word 0 |
| bus_data | input | 16 | Cell word |
| cell_avail | output | 1 | Cell-available answer value |
| cell_avail_oe | output | 1 | Drive enable for the cell-available line |
| line_rd_en | input | 1 | Line-side read advance |
| line_data | output | 16 | Word at the FIFO head |
| line_valid | output | 1 | At least one complete cell stored |
| line_sop | output | 1 | Head word is word 0 of a cell |
| drop_flag | output | 1 | One-cycle pulse: cell start dropped, FIFO full |

## Verification
A wrong word counter or a wrong slot pointer shows up on `line_data` as soon as the affected cell reaches the head of the FIFO. It can also show up as a `line_sop` on the wrong word. A wrong occupancy count shows up at the next own-address poll as a wrong `cell_avail`, or as a missing or extra `drop_flag` on the first word after the FIFO fills. Selection errors show up when a cell sent to a foreign address later appears on the line side, or when an own-address cell never appears.

// File: rtl/mphy_tx_pkg.sv
package mphy_tx_pkg;
    localparam int unsigned BUS_ADDR_W = 5;
    localparam int unsigned BUS_DATA_W = 16;

    typedef struct packed {
        logic oe;
        logic avail;
    } poll_st_t;
endpackage

// File: rtl/mphy_poll_resp.sv
module mphy_poll_resp
    import mphy_tx_pkg::*;
#(
    parameter int unsigned       ADDR_W  = BUS_ADDR_W,
    parameter logic [ADDR_W-1:0] MY_ADDR = 5'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              room,
    output logic              avail,
    output logic              avail_oe
);
    poll_st_t st_d, st_q;

    always_comb begin
        st_d.oe    = (bus_addr == MY_ADDR);
        st_d.avail = (bus_addr == MY_ADDR) && room;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign avail    = st_q.avail;
    assign avail_oe = st_q.oe;
endmodule

// File: rtl/mphy_cell_writer.sv
module mphy_cell_writer
    import mphy_tx_pkg::*;
#(
    parameter int unsigned       ADDR_W     = BUS_ADDR_W,
    parameter logic [ADDR_W-1:0] MY_ADDR    = 5'h02,
    parameter int unsigned       CELL_WORDS = 27,
    localparam int unsigned      IDX_W      = $clog2(CELL_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_en_n,
    input  logic              bus_soc,
    input  logic              full,
    output logic              wr_go,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              wr_last,
    output logic              in_cell,
    output logic              ovf
);
    typedef struct packed {
        logic             sel;
        logic             active;
        logic             ovf;
        logic [IDX_W-1:0] idx;
    } wst_t;

    wst_t st_d, st_q;
    logic take, start, cont;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        if (bus_en_n) st_d.sel = (bus_addr == MY_ADDR);

        take   = st_q.sel && !bus_en_n;
        start  = take && bus_soc;
        cont   = take && !bus_soc && st_q.active;
        wr_go  = 1'b0;
        wr_idx = st_q.idx;

        if (start) begin
            if (full) begin
                st_d.ovf    = 1'b1;
                st_d.active = 1'b0;
            end else begin
                wr_go  = 1'b1;
                wr_idx = '0;
            end
        end else if (cont) begin
            wr_go = 1'b1;
        end

        wr_last = wr_go && (wr_idx == IDX_W'(CELL_WORDS - 1));
        if (wr_go) begin
            st_d.idx    = wr_last ? '0 : wr_idx + 1'b1;
            st_d.active = !wr_last;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_cell = st_q.active;
    assign ovf     = st_q.ovf;
endmodule

// File: rtl/mphy_cell_store.sv
module mphy_cell_store
    import mphy_tx_pkg::*;
#(
    parameter int unsigned  DATA_W     = BUS_DATA_W,
    parameter int unsigned  CELL_WORDS = 27,
    parameter int unsigned  CELLS      = 4,
    localparam int unsigned IDX_W      = $clog2(CELL_WORDS),
    localparam int unsigned SLOT_W     = (CELLS > 1) ? $clog2(CELLS) : 1,
    localparam int unsigned CNT_W      = $clog2(CELLS + 1),
    localparam int unsigned DEPTH      = CELLS * CELL_WORDS,
    localparam int unsigned MA_W       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_last,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_sop,
    output logic [CNT_W-1:0]  cell_count
);
    typedef struct packed {
        logic [SLOT_W-1:0] wslot;
        logic [SLOT_W-1:0] rslot;
        logic [IDX_W-1:0]  ridx;
        logic [CNT_W-1:0]  cnt;
    } sst_t;

    sst_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [MA_W-1:0]   wa, ra;
    logic              commit, rd_fire, rd_done;

    function automatic logic [SLOT_W-1:0] slot_next(input logic [SLOT_W-1:0] s);
        return (s == SLOT_W'(CELLS - 1)) ? '0 : s + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        commit  = wr_go && wr_last;
        rd_fire = rd_en && (st_q.cnt != '0);
        rd_done = rd_fire && (st_q.ridx == IDX_W'(CELL_WORDS - 1));
        if (commit)  st_d.wslot = slot_next(st_q.wslot);
        if (rd_fire) st_d.ridx  = rd_done ? '0 : st_q.ridx + 1'b1;
        if (rd_done) st_d.rslot = slot_next(st_q.rslot);
        st_d.cnt = st_q.cnt + CNT_W'(commit) - CNT_W'(rd_done);
        wa = MA_W'(st_q.wslot) * MA_W'(CELL_WORDS) + MA_W'(wr_idx);
        ra = MA_W'(st_q.rslot) * MA_W'(CELL_WORDS) + MA_W'(st_q.ridx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_go) mem[wa] <= wr_data;
    end

    assign rd_data    = mem[ra];
    assign rd_valid   = (st_q.cnt != '0);
    assign rd_sop     = rd_valid && (st_q.ridx == '0);
    assign cell_count = st_q.cnt;
endmodule

// File: rtl/mphy_cell_tx_port.sv
module mphy_cell_tx_port
    import mphy_tx_pkg::*;
#(
    parameter int unsigned       ADDR_W     = BUS_ADDR_W,
    parameter int unsigned       DATA_W     = BUS_DATA_W,
    parameter logic [ADDR_W-1:0] MY_ADDR    = 5'h02,
    parameter int unsigned       CELL_WORDS = 27,
    parameter int unsigned       CELLS      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_en_n,
    input  logic              bus_soc,
    input  logic [DATA_W-1:0] bus_data,
    output logic              cell_avail,
    output logic              cell_avail_oe,
    input  logic              line_rd_en,
    output logic [DATA_W-1:0] line_data,
    output logic              line_valid,
    output logic              line_sop,
    output logic              drop_flag
);
    localparam int unsigned IDX_W = $clog2(CELL_WORDS);
    localparam int unsigned CNT_W = $clog2(CELLS + 1);
    localparam int unsigned OCC_W = CNT_W + 1;

    logic             wr_go, wr_last, in_cell, room, wr_commit;
    logic [IDX_W-1:0] wr_idx;
    logic [CNT_W-1:0] cell_count;
    logic [OCC_W-1:0] occupancy;

    assign occupancy = OCC_W'(cell_count) + OCC_W'(in_cell);
    assign room      = occupancy < OCC_W'(CELLS);
    assign wr_commit = wr_go && wr_last;

    mphy_poll_resp #(.ADDR_W(ADDR_W), .MY_ADDR(MY_ADDR)) u_poll (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .room(room),
        .avail(cell_avail), .avail_oe(cell_avail_oe)
    );

    mphy_cell_writer #(.ADDR_W(ADDR_W), .MY_ADDR(MY_ADDR), .CELL_WORDS(CELL_WORDS)) u_wr (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_en_n(bus_en_n),
        .bus_soc(bus_soc), .full(cell_count == CNT_W'(CELLS)),
        .wr_go(wr_go), .wr_idx(wr_idx), .wr_last(wr_last),
        .in_cell(in_cell), .ovf(drop_flag)
    );

    mphy_cell_store #(.DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .CELLS(CELLS)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_idx(wr_idx), .wr_last(wr_last),
        .wr_data(bus_data), .rd_en(line_rd_en), .rd_data(line_data),
        .rd_valid(line_valid), .rd_sop(line_sop), .cell_count(cell_count)
    );
endmodule

// File: rtl/mphy_cell_tx_port_chk.sv
module mphy_cell_tx_port_chk #(
    parameter int unsigned       ADDR_W  = 5,
    parameter logic [ADDR_W-1:0] MY_ADDR = 5'h02,
    parameter int unsigned       CELLS   = 4,
    parameter int unsigned       CNT_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_en_n,
    input logic              bus_soc,
    input logic              cell_avail,
    input logic              cell_avail_oe,
    input logic              line_valid,
    input logic              drop_flag,
    input logic              wr_commit,
    input logic [CNT_W-1:0]  cell_count
);
    a_r1_own_poll_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == MY_ADDR) |=> cell_avail_oe);

    a_r2_full_answers_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == MY_ADDR && cell_count == CNT_W'(CELLS)) |=> !cell_avail);

    a_r3_foreign_floats: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != MY_ADDR) |=> !cell_avail_oe);

    a_r6_valid_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_valid) |-> $past(wr_commit));

    a_r8_drop_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        drop_flag |-> $past(cell_count == CNT_W'(CELLS) && !bus_en_n && bus_soc));

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cell_count <= CNT_W'(CELLS));
endmodule

bind mphy_cell_tx_port mphy_cell_tx_port_chk #(
    .ADDR_W(ADDR_W), .MY_ADDR(MY_ADDR), .CELLS(CELLS), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_en_n(bus_en_n),
    .bus_soc(bus_soc), .cell_avail(cell_avail), .cell_avail_oe(cell_avail_oe),
    .line_valid(line_valid), .drop_flag(drop_flag), .wr_commit(wr_commit),
    .cell_count(cell_count)
);

// File: tb/mphy_cell_tx_port_test.sv
module mphy_cell_tx_port_test;
    localparam logic [4:0] MY = 5'h02;
    localparam int CW = 27;
    localparam int NC = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, bus_en_n, bus_soc, line_rd_en;
    logic [4:0]  bus_addr;
    logic [15:0] bus_data, line_data;
    logic        cell_avail, cell_avail_oe, line_valid, line_sop, drop_flag;

    mphy_cell_tx_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_en_n(bus_en_n),
        .bus_soc(bus_soc), .bus_data(bus_data), .cell_avail(cell_avail),
        .cell_avail_oe(cell_avail_oe), .line_rd_en(line_rd_en), .line_data(line_data),
        .line_valid(line_valid), .line_sop(line_sop), .drop_flag(drop_flag)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [15:0] expq[$];
    logic [15:0] part[$];
    int exp_cells = 0;
    bit active = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] foreign_addr();
        logic [4:0] a;
        a = 5'($urandom_range(0, 31));
        if (a == MY) a = 5'h1F;
        return a;
    endfunction

    function automatic bit exp_room();
        return (exp_cells + int'(active)) < NC;
    endfunction

    task automatic idle();
        @(negedge clk);
        bus_en_n = 1'b1; bus_soc = 1'b0; bus_addr = 5'h1F; line_rd_en = 1'b0;
    endtask

    task automatic poll(input logic [4:0] a);
        @(negedge clk);
        bus_en_n = 1'b1; bus_soc = 1'b0; bus_addr = a;
        @(negedge clk);
        if (a == MY) begin
            if (exp_room()) begin
                chk("R1 oe", 32'(cell_avail_oe), 1);
                chk("R1 avail", 32'(cell_avail), 1);
            end else begin
                chk("R2 oe", 32'(cell_avail_oe), 1);
                chk("R2 avail", 32'(cell_avail), 0);
            end
        end else begin
            chk("R3 oe", 32'(cell_avail_oe), 0);
        end
    endtask

    // self: select own address; n words, first with soc
    task automatic send(input bit self, input int n);
        bit full0;
        @(negedge clk);
        bus_en_n = 1'b1; bus_soc = 1'b0;
        bus_addr = self ? MY : foreign_addr();
        full0 = (exp_cells == NC);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 1) chk("R8 drop", 32'(drop_flag), 32'(self && full0));
            bus_en_n = 1'b0; bus_soc = (i == 0);
            bus_data = 16'($urandom);
            bus_addr = 5'($urandom_range(0, 31));
            if (self && !full0) begin
                if (i == 0) part.delete();
                part.push_back(bus_data);
            end
        end
        idle();
        if (n == 1) chk("R8 drop", 32'(drop_flag), 32'(self && full0));
        if (self && !full0) begin
            active = 1;
            if (n == CW) begin
                foreach (part[k]) expq.push_back(part[k]);
                exp_cells++;
                active = 0;
            end
        end
        chk("R6 valid after send", 32'(line_valid), 32'(exp_cells > 0));
    endtask

    task automatic send_nosoc(input int n);
        if (active) return;
        @(negedge clk);
        bus_en_n = 1'b1; bus_soc = 1'b0; bus_addr = MY;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_en_n = 1'b0; bus_soc = 1'b0; bus_data = 16'($urandom);
        end
        idle();
        chk("R5 no-soc ignored", 32'(line_valid), 32'(exp_cells > 0));
        poll(MY);
    endtask

    task automatic read_cell();
        idle();
        if (exp_cells == 0) begin
            chk("R9 empty valid", 32'(line_valid), 0);
            line_rd_en = 1'b1;
            @(negedge clk);
            line_rd_en = 1'b0;
            chk("R9 empty read ignored", 32'(line_valid), 0);
            return;
        end
        for (int i = 0; i < CW; i++) begin
            chk("R9 valid", 32'(line_valid), 1);
            chk("R9 sop", 32'(line_sop), 32'(i == 0));
            chk("R9 data", 32'(line_data), 32'(expq.pop_front()));
            line_rd_en = 1'b1;
            @(negedge clk);
        end
        line_rd_en = 1'b0;
        exp_cells--;
        chk("R6 valid after read", 32'(line_valid), 32'(exp_cells > 0));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; bus_en_n = 1'b1; bus_soc = 1'b0; bus_addr = MY;
        bus_data = '0; line_rd_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 oe", 32'(cell_avail_oe), 0);
        chk("R10 avail", 32'(cell_avail), 0);
        chk("R10 valid", 32'(line_valid), 0);
        chk("R10 drop", 32'(drop_flag), 0);
        rst_n = 1'b1;
        idle();

        poll(MY);                 // R1
        poll(5'h1F);              // R3 null address
        poll(5'h00);              // R3
        send_nosoc(5);            // R5
        read_cell();              // R9 empty
        send(1, CW);              // R6
        send(0, CW);              // R4 foreign cell ignored
        read_cell();              // R9
        send(1, 10);              // R7 partial
        poll(MY);
        send(1, CW);              // R7 restart
        read_cell();
        for (int c = 0; c < NC; c++) send(1, CW);
        poll(MY);                 // R2 full
        send(1, 3);               // R8 dropped
        send(1, 1);               // R8 single word drop
        read_cell();
        send(1, 5);               // last slot taken by partial
        poll(MY);                 // R2
        while (exp_cells > 0) read_cell();

        for (int op = 0; op < 300; op++) begin
            case ($urandom_range(0, 6))
                0: poll(MY);
                1: poll(foreign_addr());
                2, 3: send(1, CW);
                4: send(1, $urandom_range(1, CW - 1));
                5: send(0, $urandom_range(1, CW));
                default: read_cell();
            endcase
        end
        while (exp_cells > 0) read_cell();
        read_cell();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule